// File: doc/BRIEF.md
# Key Matrix Scanner with Serial Readout

This block scans a 12-by-4 key matrix. It drives one of twelve source lines at a time and samples four return inputs for that line. The results go into a 48-bit key map that is read out one bit at a time. The display scanner that owns the multiplexed outputs sets the pace with two pulses. A slot pulse marks the end of one display slot; the returns are latched there and the scan moves to the next source line. A frame pulse marks the end of a display frame. Each frame drives half of the source lines, so one complete scan takes two frames.

The returns go first into a shadow array. The whole array is copied into the readable key map only at the end of the second frame. A read therefore always sees one complete scan and never a mix of two. A stop pulse (issued on a display-mode change) halts scanning and leaves the previous key map in place. A start pulse (issued on a display-on command) restarts the scan at the first source line of the first half.

Readout is a bit stream. A read-start pulse points the stream at bit 0. Each shift pulse moves it one place forward, least significant bit first. The stream runs through all six bytes without a break, and any position past the last key reads as 0.

Top module: `keymatrix_scanner`

## Requirements
- R1: After reset no source line is driven, the read pointer is at bit 0, and every key-map bit reads 0.
- R2: After a start pulse, source line 1 (src_drive bit 0) is driven alone, and at most one source line is ever driven at a time.
- R3: Each slot pulse latches the returns for the driven line and moves to the next line. After the sixth slot pulse of a frame, no line is driven until the frame pulse.
- R4: The first frame drives lines 1 to 6 and the second frame drives lines 7 to 12. After the second frame pulse the scan returns to line 1.
- R5: The return input K(r+1) sampled while line L (0-based) is driven is stored at key-map bit 4·L+r. Byte k therefore holds line 2k+1 in bits 3:0 and line 2k+2 in bits 7:4.
- R6: The key map changes only at the frame pulse that closes the second frame, and then all 48 bits change together. A read before that pulse sees the previous scan.
- R7: A stop pulse clears the line drive, and slot and frame pulses are then ignored with no update of the key map. Stop wins over a start pulse in the same cycle. A later start pulse begins a fresh scan.
- R8: rd_bit shows key-map bit p, where p is the read pointer. A read-start pulse sets p to 0, and each shift pulse adds one, so bytes are read LSB first with byte k+1 bit 0 following byte k bit 7. A read-start pulse wins over a shift pulse in the same cycle.
- R9: Once the pointer passes bit 47 it stays at that position and rd_bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_start | input | 1 | Pulse: begin scanning from line 1 (display on) |
| scan_stop | input | 1 | Pulse: halt scanning (mode change) |
| frame_end | input | 1 | Pulse: end of a display frame |
| slot_tick | input | 1 | Pulse: end of a display slot, latch returns |
| key_in | input | 4 | Matrix return inputs K1..K4 (bit 0 = K1) |
| rd_start | input | 1 | Pulse: start of a read, pointer to bit 0 |
| rd_shift | input | 1 | Pulse: advance the read pointer by one bit |
| src_drive | output | 12 | One-hot key source drive, bit 0 = line 1 |
| rd_bit | output | 1 | Current readout bit |

## Verification
The assertions assume that each control input is a single-cycle pulse sampled on the rising edge. They also assume that key_in is settled in the cycle the slot pulse arrives, which requires the matrix to respond combinationally to src_drive. The bench changes every input on the falling edge, holds each pulse for exactly one cycle, and models the matrix as a pressed-key pattern that is ORed onto the returns of whichever line is driven. This meets both assumptions. The same-cycle start and stop case, and the same-cycle start and shift case, are driven deliberately to exercise the stated priorities.

// File: rtl/kscan_pkg.sv
// Package: shared defaults and the scan state type for the key scanner.
// Assumes nothing; holds constants only.
package kscan_pkg;
    localparam int unsigned KS_NUM_SRC = 12;
    localparam int unsigned KS_NUM_RET = 4;

    typedef enum logic {
        KS_IDLE = 1'b0,
        KS_RUN  = 1'b1
    } ks_state_e;
endpackage

// File: rtl/kscan_seq.sv
// Line sequencer: steps through the source lines, half of them per frame,
// and produces the capture enable and the end-of-scan commit pulse.
// Assumes slot_tick and frame_end are single-cycle pulses; NUM_SRC is even.
module kscan_seq
    import kscan_pkg::*;
#(
    parameter int unsigned NUM_SRC = KS_NUM_SRC,
    localparam int unsigned LPF    = NUM_SRC / 2,
    localparam int unsigned LINE_W = $clog2(NUM_SRC),
    localparam int unsigned IDX_W  = $clog2(LPF + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_start,
    input  logic               scan_stop,
    input  logic               slot_tick,
    input  logic               frame_end,
    output logic [NUM_SRC-1:0] src_drive,
    output logic               cap_en,
    output logic [LINE_W-1:0]  cap_line,
    output logic               commit
);
    ks_state_e        state;
    logic             half;
    logic [IDX_W-1:0] idx;
    logic             in_slot;
    logic             quiet;

    // Current line index from the half and the slot position.
    always_comb begin
        cap_line = LINE_W'(idx) + (half ? LINE_W'(LPF) : '0);
        in_slot  = (state == KS_RUN) && (idx < IDX_W'(LPF));
        quiet    = !scan_stop && !scan_start;
        cap_en   = in_slot && slot_tick && quiet;
        commit   = (state == KS_RUN) && frame_end && half && quiet;
    end

    // One-hot source drive, one decoder per line.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_drive
        assign src_drive[g] = in_slot && (cap_line == LINE_W'(g));
    end

    // Scan state, frame half and slot position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KS_IDLE;
            half  <= 1'b0;
            idx   <= '0;
        end else if (scan_stop) begin
            state <= KS_IDLE;
            half  <= 1'b0;
            idx   <= '0;
        end else if (scan_start) begin
            state <= KS_RUN;
            half  <= 1'b0;
            idx   <= '0;
        end else if (state == KS_RUN) begin
            if (frame_end) begin
                idx  <= '0;
                half <= ~half;
            end else if (slot_tick && in_slot) begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/kscan_capture.sv
// Capture store: latches the returns of the driven line into a shadow
// array and copies the shadow to the readable key map on commit.
// Assumes cap_line < NUM_SRC whenever cap_en is high.
module kscan_capture
    import kscan_pkg::*;
#(
    parameter int unsigned NUM_SRC = KS_NUM_SRC,
    parameter int unsigned NUM_RET = KS_NUM_RET,
    localparam int unsigned TOTAL  = NUM_SRC * NUM_RET,
    localparam int unsigned LINE_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic [LINE_W-1:0]  cap_line,
    input  logic [NUM_RET-1:0] key_in,
    input  logic               commit,
    output logic [TOTAL-1:0]   key_map
);
    logic [TOTAL-1:0] shadow;
    logic [TOTAL-1:0] shadow_nxt;

    // Merge this cycle's sample into the shadow, line-major packing.
    always_comb begin
        shadow_nxt = shadow;
        if (cap_en) begin
            shadow_nxt[int'(cap_line) * NUM_RET +: NUM_RET] = key_in;
        end
    end

    // Shadow update every cycle; key map only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow  <= '0;
            key_map <= '0;
        end else begin
            shadow <= shadow_nxt;
            if (commit) begin
                key_map <= shadow_nxt;
            end
        end
    end
endmodule

// File: rtl/kscan_readout.sv
// Readout pointer: selects one key-map bit for the serial stream,
// restarting on rd_start and saturating one past the last bit.
// Assumes rd_start and rd_shift are single-cycle pulses.
module kscan_readout #(
    parameter int unsigned TOTAL   = 48,
    localparam int unsigned PTR_W  = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic             rd_shift,
    input  logic [TOTAL-1:0] key_map,
    output logic             rd_bit,
    output logic [PTR_W-1:0] rd_ptr
);
    // Bit select, zero beyond the array.
    always_comb begin
        rd_bit = 1'b0;
        for (int i = 0; i < TOTAL; i++) begin
            if (rd_ptr == PTR_W'(i)) rd_bit = key_map[i];
        end
    end

    // Pointer restart and saturating advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rd_start) begin
            rd_ptr <= '0;
        end else if (rd_shift && (rd_ptr < PTR_W'(TOTAL))) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/keymatrix_scanner.sv
// Top: key matrix scanner with a packed, bit-serial readout.
// Assumes all control inputs are one-cycle pulses on clk and key_in
// settles combinationally from src_drive within the slot.
module keymatrix_scanner
    import kscan_pkg::*;
#(
    parameter int unsigned NUM_SRC = KS_NUM_SRC,
    parameter int unsigned NUM_RET = KS_NUM_RET
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_start,
    input  logic               scan_stop,
    input  logic               frame_end,
    input  logic               slot_tick,
    input  logic [NUM_RET-1:0] key_in,
    input  logic               rd_start,
    input  logic               rd_shift,
    output logic [NUM_SRC-1:0] src_drive,
    output logic               rd_bit
);
    localparam int unsigned TOTAL  = NUM_SRC * NUM_RET;
    localparam int unsigned LINE_W = $clog2(NUM_SRC);
    localparam int unsigned PTR_W  = $clog2(TOTAL + 1);

    logic              cap_en;
    logic [LINE_W-1:0] cap_line;
    logic              commit;
    logic [TOTAL-1:0]  key_map;
    logic [PTR_W-1:0]  rd_ptr;

    kscan_seq #(.NUM_SRC(NUM_SRC)) u_seq (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_stop(scan_stop),
        .slot_tick(slot_tick), .frame_end(frame_end), .src_drive(src_drive),
        .cap_en(cap_en), .cap_line(cap_line), .commit(commit)
    );

    kscan_capture #(.NUM_SRC(NUM_SRC), .NUM_RET(NUM_RET)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_line(cap_line),
        .key_in(key_in), .commit(commit), .key_map(key_map)
    );

    kscan_readout #(.TOTAL(TOTAL)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_shift(rd_shift),
        .key_map(key_map), .rd_bit(rd_bit), .rd_ptr(rd_ptr)
    );
endmodule

// File: rtl/kscan_checker.sv
// Checker: temporal properties of the key scanner, bound to the top.
// Assumes single-cycle control pulses sampled on the rising edge.
module kscan_checker #(
    parameter int unsigned NUM_SRC = 12,
    parameter int unsigned NUM_RET = 4,
    localparam int unsigned TOTAL  = NUM_SRC * NUM_RET,
    localparam int unsigned PTR_W  = $clog2(TOTAL + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scan_start,
    input logic               scan_stop,
    input logic               frame_end,
    input logic               slot_tick,
    input logic               rd_start,
    input logic               rd_shift,
    input logic [NUM_SRC-1:0] src_drive,
    input logic               rd_bit,
    input logic               commit,
    input logic [TOTAL-1:0]   key_map,
    input logic [PTR_W-1:0]   rd_ptr
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (src_drive == '0) && (rd_ptr == '0));

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_drive));

    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && !frame_end && !scan_stop && !scan_start && (src_drive != '0))
        |=> (src_drive != $past(src_drive)));

    p_hold_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(key_map));

    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_stop |=> (src_drive == '0));

    p_ptr_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> (rd_ptr == '0));

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_start && rd_shift && (rd_ptr < PTR_W'(TOTAL)))
        |=> (rd_ptr == $past(rd_ptr) + 1'b1));

    p_tail_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr >= PTR_W'(TOTAL)) |-> !rd_bit);
endmodule

bind keymatrix_scanner kscan_checker #(.NUM_SRC(NUM_SRC), .NUM_RET(NUM_RET)) u_chk (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_stop(scan_stop),
    .frame_end(frame_end), .slot_tick(slot_tick), .rd_start(rd_start),
    .rd_shift(rd_shift), .src_drive(src_drive), .rd_bit(rd_bit),
    .commit(commit), .key_map(key_map), .rd_ptr(rd_ptr)
);

// File: tb/keymatrix_scanner_bench.sv
// Directed bench: a pressed-key pattern models the matrix; each task
// drives one scenario and checks its own results at the ports.
module keymatrix_scanner_bench;
    localparam int NS = 12;
    localparam int NR = 4;
    localparam int NT = NS * NR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_start = 1'b0, scan_stop = 1'b0, frame_end = 1'b0;
    logic          slot_tick = 1'b0, rd_start = 1'b0, rd_shift = 1'b0;
    logic [NR-1:0] key_in;
    logic [NS-1:0] src_drive;
    logic          rd_bit;
    logic [NT-1:0] pat = '0;
    int            checks = 0;
    int            errors = 0;

    localparam logic [NT-1:0] PAT_A = 48'h8000_2000_0401;
    localparam logic [NT-1:0] PAT_B = 48'h5A3C_0F96_1E2D;
    localparam logic [NT-1:0] PAT_C = '1;

    always #5ns clk = ~clk;

    keymatrix_scanner u_keymatrix_scanner (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_stop(scan_stop),
        .frame_end(frame_end), .slot_tick(slot_tick), .key_in(key_in),
        .rd_start(rd_start), .rd_shift(rd_shift), .src_drive(src_drive), .rd_bit(rd_bit)
    );

    // Matrix model: a pressed key connects its source line to its return.
    always_comb begin
        key_in = '0;
        for (int l = 0; l < NS; l++)
            for (int r = 0; r < NR; r++)
                if (src_drive[l] && pat[l*NR + r]) key_in[r] = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // mask bits: 0 start, 1 stop, 2 slot, 3 frame, 4 rd_start, 5 rd_shift
    task automatic pulse(input logic [5:0] m);
        @(negedge clk);
        scan_start = m[0]; scan_stop = m[1]; slot_tick = m[2];
        frame_end = m[3]; rd_start = m[4]; rd_shift = m[5];
        @(negedge clk);
        {scan_start, scan_stop, slot_tick, frame_end, rd_start, rd_shift} = '0;
        #1;
    endtask

    task automatic slots(input int n);
        for (int i = 0; i < n; i++) pulse(6'b000100);
    endtask

    task automatic full_scan();
        for (int f = 0; f < 2; f++) begin
            slots(6);
            pulse(6'b001000);
        end
    endtask

    task automatic read_bits(input int n, output logic [63:0] got);
        got = '0;
        pulse(6'b010000);
        for (int i = 0; i < n; i++) begin
            got[i] = rd_bit;
            pulse(6'b100000);
        end
    endtask

    task automatic t_reset();
        logic [63:0] got;
        chk(src_drive == '0, "R1 drive after reset", 64'(src_drive), 0);
        read_bits(NT, got);
        chk(got[NT-1:0] == '0, "R1 key map after reset", got, 0);
    endtask

    task automatic t_sequence();
        pulse(6'b000001);
        chk(src_drive == 12'h001, "R2 first line after start", 64'(src_drive), 1);
        for (int i = 0; i < 6; i++) begin
            chk(src_drive == NS'(1 << i), "R3 line step frame 1", 64'(src_drive), 64'(1 << i));
            pulse(6'b000100);
        end
        chk(src_drive == '0, "R3 idle after six slots", 64'(src_drive), 0);
        pulse(6'b001000);
        for (int i = 0; i < 6; i++) begin
            chk(src_drive == NS'(1 << (6 + i)), "R4 line step frame 2", 64'(src_drive), 64'(1 << (6 + i)));
            pulse(6'b000100);
        end
        pulse(6'b001000);
        chk(src_drive == 12'h001, "R4 wrap to line 1", 64'(src_drive), 1);
    endtask

    task automatic t_pack();
        logic [63:0] got;
        logic [7:0]  exp_b [6];
        exp_b = '{8'h01, 8'h04, 8'h00, 8'h20, 8'h00, 8'h80};
        pat = PAT_A;
        full_scan();
        read_bits(NT, got);
        chk(got[NT-1:0] == PAT_A, "R5 R8 full stream", got, 64'(PAT_A));
        for (int k = 0; k < 6; k++)
            chk(got[8*k +: 8] == exp_b[k], "R5 byte packing", 64'(got[8*k +: 8]), 64'(exp_b[k]));
        pulse(6'b010000);
        pulse(6'b100000);
        chk(rd_bit == PAT_A[1], "R8 pointer at bit 1", 64'(rd_bit), 64'(PAT_A[1]));
        pulse(6'b110000);
        chk(rd_bit == PAT_A[0], "R8 restart beats shift", 64'(rd_bit), 64'(PAT_A[0]));
    endtask

    task automatic t_atomic();
        logic [63:0] got;
        pat = PAT_B;
        slots(6);
        pulse(6'b001000);
        slots(3);
        read_bits(NT, got);
        chk(got[NT-1:0] == PAT_A, "R6 old map mid second frame", got, 64'(PAT_A));
        slots(3);
        read_bits(NT, got);
        chk(got[NT-1:0] == PAT_A, "R6 old map before last frame pulse", got, 64'(PAT_A));
        pulse(6'b001000);
        read_bits(NT, got);
        chk(got[NT-1:0] == PAT_B, "R6 new map after commit", got, 64'(PAT_B));
    endtask

    task automatic t_stop();
        logic [63:0] got;
        pat = PAT_C;
        slots(6);
        pulse(6'b000010);
        chk(src_drive == '0, "R7 drive cleared by stop", 64'(src_drive), 0);
        slots(6);
        pulse(6'b001000);
        slots(6);
        pulse(6'b001000);
        chk(src_drive == '0, "R7 pulses ignored when stopped", 64'(src_drive), 0);
        read_bits(NT, got);
        chk(got[NT-1:0] == PAT_B, "R7 map kept while stopped", got, 64'(PAT_B));
        pulse(6'b000011);
        chk(src_drive == '0, "R7 stop beats start", 64'(src_drive), 0);
        pulse(6'b000001);
        chk(src_drive == 12'h001, "R2 restart at line 1", 64'(src_drive), 1);
        full_scan();
        read_bits(NT, got);
        chk(got[NT-1:0] == PAT_C, "R7 fresh scan after restart", got, 64'(PAT_C));
    endtask

    task automatic t_tail();
        logic [63:0] got;
        read_bits(NT + 8, got);
        chk(got[NT-1:0] == PAT_C, "R9 stream before end", got, 64'(PAT_C));
        chk(got[NT+7:NT] == '0, "R9 zeros past last bit", 64'(got[NT+7:NT]), 0);
    endtask

    initial begin
        #2ms;
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_sequence();
        t_pack();
        t_atomic();
        t_stop();
        t_tail();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule